// File: doc/BRIEF.md
# Programmable Four-Source Multiplexer Logic Cell

This block evaluates any single-output Boolean function of `NUM_VARS` variables with one multiplexer. The low `NUM_VARS-1` variable bits steer the selection. The top variable bit, called the data variable, reaches the data side of the multiplexer in both true and complemented form. A bank of configuration registers holds a 2-bit source code for each of the `2**(NUM_VARS-1)` legs. Each code picks what that leg carries: constant low, constant high, the data variable, or its complement.

Software or a sequencer loads the codes one at a time through a synchronous write port, and can change them at any time. The function output is combinational. It follows the variable inputs within the same cycle and the stored codes one clock edge after a write. The parameter `USE_TREE` chooses how the final selection is built: a balanced tree of 2:1 stages, or a single indexed selection.

Top module: `mxlf_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every configuration entry holds code 2'b00, so `func_o` is 0 for every value of `vars_i`.
- R2: A leg holding code 2'b00 drives 0 onto the output whenever that leg is selected.
- R3: A leg holding code 2'b01 drives 1 onto the output whenever that leg is selected.
- R4: A leg holding code 2'b10 drives the data variable `vars_i[NUM_VARS-1]` onto the output whenever that leg is selected.
- R5: A leg holding code 2'b11 drives the inverse of `vars_i[NUM_VARS-1]` onto the output whenever that leg is selected.
- R6: The leg selected is the one whose index k equals the unsigned value of `vars_i[NUM_VARS-2:0]`, so for every programmed function the output matches the truth table built from the codes over all `2**NUM_VARS` input values.
- R7: A write with `cfg_we_i` high stores `cfg_code_i` into entry `cfg_addr_i` at the rising clock edge. Before that edge the output still reflects the old code.
- R8: When `cfg_we_i` is low, the values on `cfg_addr_i` and `cfg_code_i` have no effect on any entry.
- R9: A write changes only the addressed entry. All other legs keep their codes.
- R10: `func_o` responds to a change on `vars_i` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset, clears all codes |
| vars_i | input | NUM_VARS | Function variables; low bits select, top bit is the data variable |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | NUM_VARS-1 | Index of the leg being written |
| cfg_code_i | input | 2 | Source code: 00 zero, 01 one, 10 data, 11 inverted data |
| func_o | output | 1 | Function result |

## Verification
Evaluation and reprogramming can fall in the same cycle. The bench provokes this by driving a write to the leg that `vars_i` currently selects. It judges the result twice: inside that cycle the output must still follow the old code, and just after the rising edge it must follow the new one. Random functions are then loaded entry by entry. After each load the bench sweeps the whole input space against a reference truth table kept in its scoreboard. Writes with the enable low are also presented with live address and code, and the bench confirms that the output does not change.

// File: rtl/mxlf_pkg.sv
package mxlf_pkg;

   localparam int unsigned MXLF_MIN_VARS = 2;
   localparam int unsigned MXLF_MAX_VARS = 6;
   localparam int unsigned MXLF_CODE_W   = 2;

   // Leg source codes; the encoding is part of the write interface.
   typedef enum logic [MXLF_CODE_W-1:0] {
      SRC_ZERO = 2'b00,
      SRC_ONE  = 2'b01,
      SRC_TRUE = 2'b10,
      SRC_COMP = 2'b11
   } src_code_e;

   // Value a leg carries for a given code and data variable.
   function automatic logic leg_value(input src_code_e code, input logic dvar);
      logic v;
      unique case (code)
         SRC_ZERO: v = 1'b0;
         SRC_ONE:  v = 1'b1;
         SRC_TRUE: v = dvar;
         SRC_COMP: v = ~dvar;
         default:  v = 1'b0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/mxlf_cfg_store.sv
module mxlf_cfg_store
   import mxlf_pkg::*;
#(
   parameter  int unsigned IDX_W   = 3,
   localparam int unsigned ENTRIES = 1 << IDX_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we_i,
   input  logic [IDX_W-1:0]            addr_i,
   input  logic [MXLF_CODE_W-1:0]      code_i,
   output src_code_e [ENTRIES-1:0]     codes_o
);

   src_code_e wr_code;
   assign wr_code = src_code_e'(code_i);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic      hit;
      src_code_e cur;

      assign hit = we_i && (addr_i == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cur <= SRC_ZERO;
         end else if (hit) begin
            cur <= wr_code;
         end
      end

      assign codes_o[e] = cur;
   end

endmodule

// File: rtl/mxlf_leg_sel.sv
module mxlf_leg_sel
   import mxlf_pkg::*;
#(
   parameter  int unsigned IDX_W   = 3,
   localparam int unsigned ENTRIES = 1 << IDX_W
) (
   input  src_code_e [ENTRIES-1:0] codes_i,
   input  logic                    dvar_i,
   output logic [ENTRIES-1:0]      legs_o
);

   logic dvar_n;
   assign dvar_n = ~dvar_i;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_leg
      logic v;
      always_comb begin
         unique case (codes_i[e])
            SRC_ZERO: v = 1'b0;
            SRC_ONE:  v = 1'b1;
            SRC_TRUE: v = dvar_i;
            SRC_COMP: v = dvar_n;
            default:  v = leg_value(codes_i[e], dvar_i);
         endcase
      end
      assign legs_o[e] = v;
   end

endmodule

// File: rtl/mxlf_sel_tree.sv
module mxlf_sel_tree #(
   parameter  int unsigned IDX_W    = 3,
   parameter  bit          USE_TREE = 1'b1,
   localparam int unsigned ENTRIES  = 1 << IDX_W,
   localparam int unsigned NODES    = 2 * ENTRIES - 1
) (
   input  logic [ENTRIES-1:0] legs_i,
   input  logic [IDX_W-1:0]   sel_i,
   output logic               y_o
);

   if (USE_TREE) begin : g_tree
      // Heap layout: node 0 is the root, leaves sit at ENTRIES-1+k.
      logic [NODES-1:0] node;

      for (genvar k = 0; k < ENTRIES; k++) begin : g_leaf
         assign node[ENTRIES-1+k] = legs_i[k];
      end

      for (genvar i = 0; i < ENTRIES - 1; i++) begin : g_stage
         localparam int unsigned DEPTH = $clog2(i + 2) - 1;
         localparam int unsigned SBIT  = IDX_W - 1 - DEPTH;
         assign node[i] = sel_i[SBIT] ? node[2*i+2] : node[2*i+1];
      end

      assign y_o = node[0];
   end else begin : g_flat
      assign y_o = legs_i[sel_i];
   end

endmodule

// File: rtl/mxlf_top.sv
module mxlf_top
   import mxlf_pkg::*;
#(
   parameter  int unsigned NUM_VARS = 4,
   parameter  bit          USE_TREE = 1'b1,
   localparam int unsigned IDX_W    = NUM_VARS - 1,
   localparam int unsigned ENTRIES  = 1 << IDX_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_VARS-1:0]    vars_i,
   input  logic                   cfg_we_i,
   input  logic [IDX_W-1:0]       cfg_addr_i,
   input  logic [MXLF_CODE_W-1:0] cfg_code_i,
   output logic                   func_o
);

   if (NUM_VARS < MXLF_MIN_VARS || NUM_VARS > MXLF_MAX_VARS) begin : g_bad_vars
      $error("mxlf_top: NUM_VARS out of supported range");
   end

   src_code_e [ENTRIES-1:0] codes;
   logic      [ENTRIES-1:0] legs;
   logic                    dvar;
   logic      [IDX_W-1:0]   sel;

   assign dvar = vars_i[NUM_VARS-1];
   assign sel  = vars_i[IDX_W-1:0];

   mxlf_cfg_store #(.IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we_i),
      .addr_i  (cfg_addr_i),
      .code_i  (cfg_code_i),
      .codes_o (codes)
   );

   mxlf_leg_sel #(.IDX_W(IDX_W)) u_legs (
      .codes_i (codes),
      .dvar_i  (dvar),
      .legs_o  (legs)
   );

   mxlf_sel_tree #(.IDX_W(IDX_W), .USE_TREE(USE_TREE)) u_sel (
      .legs_i (legs),
      .sel_i  (sel),
      .y_o    (func_o)
   );

endmodule

// File: rtl/mxlf_chk.sv
module mxlf_chk #(
   parameter  int unsigned NUM_VARS = 4,
   localparam int unsigned IDX_W    = NUM_VARS - 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_VARS-1:0] vars_i,
   input logic                cfg_we_i,
   input logic [IDX_W-1:0]    cfg_addr_i,
   input logic [1:0]          cfg_code_i,
   input logic                func_o
);

   // R1: output is low on the first edge after reset release
   a_r1_reset_zero: assert property (@(posedge clk)
      $rose(rst_n) |-> !func_o);

   // R2: a zero code, once written, yields 0 on its leg
   a_r2_zero_leg: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && cfg_code_i == 2'b00) |=>
      ((vars_i[IDX_W-1:0] != $past(cfg_addr_i)) || !func_o));

   // R3 R7: a one code, once written, yields 1 on its leg at the next edge
   a_r3_one_leg: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && cfg_code_i == 2'b01) |=>
      ((vars_i[IDX_W-1:0] != $past(cfg_addr_i)) || func_o));

   // R4: a true-data code passes the data variable
   a_r4_true_leg: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && cfg_code_i == 2'b10) |=>
      ((vars_i[IDX_W-1:0] != $past(cfg_addr_i)) || (func_o == vars_i[NUM_VARS-1])));

   // R5: an inverted-data code passes the complement
   a_r5_comp_leg: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && cfg_code_i == 2'b11) |=>
      ((vars_i[IDX_W-1:0] != $past(cfg_addr_i)) || (func_o != vars_i[NUM_VARS-1])));

   // R8: with no write and steady variables the output holds
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we_i |=> (!$stable(vars_i) || $stable(func_o)));

endmodule

bind mxlf_top mxlf_chk #(.NUM_VARS(NUM_VARS)) u_mxlf_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vars_i     (vars_i),
   .cfg_we_i   (cfg_we_i),
   .cfg_addr_i (cfg_addr_i),
   .cfg_code_i (cfg_code_i),
   .func_o     (func_o)
);

// File: tb/mxlf_top_tb.sv
`timescale 1ns/1ps
module mxlf_top_tb;

   localparam int N       = 4;
   localparam int IW      = N - 1;
   localparam int ENT     = 1 << IW;
   localparam int COMBOS  = 1 << N;
   localparam real HALF   = 2.0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  vars = '0;
   logic          we = 1'b0;
   logic [IW-1:0] addr = '0;
   logic [1:0]    code = '0;
   logic          func;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [1:0] shadow [ENT];

   typedef struct {
      logic         exp;
      string        tag;
      logic [N-1:0] v;
   } item_t;
   item_t q[$];
   event smp;

   always #(HALF) clk = ~clk;

   mxlf_top #(.NUM_VARS(N)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .vars_i     (vars),
      .cfg_we_i   (we),
      .cfg_addr_i (addr),
      .cfg_code_i (code),
      .func_o     (func)
   );

   // Reference: value of the function from the shadow codes.
   function automatic logic ref_val(logic [N-1:0] v);
      logic d;
      d = v[N-1];
      case (shadow[v[IW-1:0]])
         2'b00:   return 1'b0;
         2'b01:   return 1'b1;
         2'b10:   return d;
         default: return ~d;
      endcase
   endfunction

   function automatic string code_tag(logic [N-1:0] v);
      case (shadow[v[IW-1:0]])
         2'b00:   return "R2/R6";
         2'b01:   return "R3/R6";
         2'b10:   return "R4/R6";
         default: return "R5/R6";
      endcase
   endfunction

   // Monitor: pops expectations and compares with the output.
   initial begin
      forever begin
         @(smp);
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (func !== it.exp) begin
               errors++;
               $display("FAIL %s vars=%b actual=%b expected=%b", it.tag, it.v, func, it.exp);
            end
         end
      end
   end

   task automatic expect_now(logic e, string tag);
      item_t it;
      it.exp = e; it.tag = tag; it.v = vars;
      q.push_back(it);
      -> smp;
      #0.1;
   endtask

   task automatic apply(logic [N-1:0] v, string tag);
      @(negedge clk);
      vars = v;
      #0.5;
      expect_now(ref_val(v), tag);
   endtask

   task automatic sweep(string tag);
      for (int c = 0; c < COMBOS; c++) begin
         if (tag == "")
            apply(N'(c), code_tag(N'(c)));
         else
            apply(N'(c), tag);
      end
   endtask

   task automatic cfg_write(logic [IW-1:0] a, logic [1:0] c);
      @(negedge clk);
      we = 1'b1; addr = a; code = c;
      @(posedge clk);
      shadow[a] = c;
      #0.5;
      we = 1'b0;
   endtask

   initial begin
      for (int e = 0; e < ENT; e++) shadow[e] = 2'b00;

      // R1: outputs while in reset and after release
      repeat (2) @(negedge clk);
      sweep("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      sweep("R1 after release");

      // R3 R9: one leg high, the rest must stay zero
      cfg_write(IW'(5), 2'b01);
      sweep("R9 single leg");

      // Every code on every leg, checked with full sweeps
      for (int c = 0; c < 4; c++) begin
         for (int e = 0; e < ENT; e++) cfg_write(IW'(e), 2'(c));
         sweep("");
      end

      // R6: random functions against the reference table
      for (int r = 0; r < 8; r++) begin
         for (int e = 0; e < ENT; e++) cfg_write(IW'(e), 2'($urandom_range(3, 0)));
         sweep("");
      end

      // R7: write to the selected leg in the same cycle
      cfg_write(IW'(2), 2'b00);
      @(negedge clk);
      vars = {1'b1, IW'(2)};
      we = 1'b1; addr = IW'(2); code = 2'b01;
      #0.5;
      expect_now(1'b0, "R7 before edge");
      @(posedge clk);
      shadow[2] = 2'b01;
      #0.5;
      we = 1'b0;
      expect_now(1'b1, "R7 after edge");

      // R8: enable low with live address and code
      for (int e = 0; e < ENT; e++) cfg_write(IW'(e), 2'b10);
      @(negedge clk);
      vars = {1'b1, IW'(4)};
      we = 1'b0; addr = IW'(4); code = 2'b11;
      repeat (2) @(posedge clk);
      #0.5;
      expect_now(1'b1, "R8 ignored write");
      addr = '0; code = 2'b00;
      sweep("R8 table intact");

      // R10: output follows inputs within one clock phase
      cfg_write(IW'(1), 2'b11);
      @(posedge clk);
      #0.3;
      vars = {1'b0, IW'(1)};
      #0.3;
      expect_now(1'b1, "R10 no edge");
      vars = {1'b1, IW'(1)};
      #0.3;
      expect_now(1'b0, "R10 no edge");

      #1;
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule